// File: doc/BRIEF.md
# MSI Capability Registers and Message Generator

This block holds the register set of a PCI-style message-signalled interrupt capability and turns per-vector interrupt requests into memory-write messages. A configuration port takes 2-byte and 4-byte writes at byte offsets inside the capability. Reads are combinational and return the aligned 32-bit word at the addressed offset. Each message carries a 64-bit address and a 16-bit data word. Messages leave on a valid/ready port, one at a time.

Two static strap inputs set the register layout: 64-bit addressing and per-vector masking. A third strap gives the advertised multiple-message capability. The straps move the message data, upper address, mask and pending registers to different offsets and change the reported capability size. A request for a vector that is masked, or that arrives while the capability is disabled, is held as pending. It is sent later, once the vector becomes sendable.

Top module: `msi_cap_gen`

## Requirements
- R1: The control half-word is {7'b0, strap_pvmask, strap_addr64, mme[2:0], strap_mmcap[2:0], en}, with en at bit 0. It reads in bits 31:16 of the word at offset 0x0, and bits 15:0 of that word read zero. After reset, en and mme are 0.
- R2: A control write changes only en and mme. The control value comes from cfg_wdata[15:0] for a 2-byte write at offset 0x2, and from cfg_wdata[31:16] for a 4-byte write at offset 0x0.
- R3: The lower address register is at offset 0x4 and takes only 4-byte writes. Its bits 1:0 always read 0.
- R4: With strap_addr64=1, the upper address is at 0x8, message data at 0xC, mask at 0x10 and pending at 0x14.
- R5: With strap_addr64=0, there is no upper address register, which then counts as zero. Message data is at 0x8, mask at 0xC and pending at 0x10. Mask and pending exist only with strap_pvmask=1, and pending is read-only.
- R6: The message data register takes a 2-byte write or a 4-byte write. A 4-byte write keeps cfg_wdata[15:0] only.
- R7: A write of any length other than 2 or 4, or to an offset absent in the current layout, changes nothing. Such a write raises cfg_err for exactly the cycle after it. A read of an absent offset returns 0.
- R8: cap_bytes = 10, plus 4 when strap_addr64=1, plus 10 when strap_pvmask=1.
- R9: The number of usable vectors is 1<<mme for mme 0..5 and 0 for mme 6 or 7. A request for a vector at or above that count is dropped and never becomes pending.
- R10: A message's address is {upper, lower} and its data is the message data register ORed with the vector index.
- R11: A vector is masked only when strap_pvmask=1 and its mask bit is 1. A masked vector sends nothing; its request stays pending and is sent after the mask bit clears.
- R12: While en=0, no message is sent and requests stay pending. They are sent once en returns to 1.
- R13: Among sendable pending vectors, the lowest index goes first, one message per handshake. While msg_ready is low, msg_valid, msg_addr and msg_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr64 | input | 1 | 64-bit address capable strap |
| strap_pvmask | input | 1 | Per-vector masking capable strap |
| strap_mmcap | input | 3 | Multiple-message capable strap |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Byte offset inside the capability |
| cfg_len | input | 3 | Write length in bytes |
| cfg_wdata | input | 32 | Write value, LSB aligned |
| cfg_rdata | output | 32 | Aligned read word at cfg_addr |
| cfg_err | output | 1 | One-cycle flag for an ignored write |
| cap_bytes | output | 5 | Capability size in bytes |
| irq_req | input | NVEC | Per-vector request pulses |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |

## Verification
A wrong layout decode shows up at once as a wrong read word or a wrong cfg_err in the cycle after a write. Wrong pending or mask state is slower to surface. It shows as a missing message, an extra message, or a message out of order, two cycles after the request or after the unmasking write. The pending word can be read back, which exposes a dropped or stuck bit without waiting for a message. A bad index merge appears in msg_data as soon as the message is offered.

// File: rtl/msi_cap_gen.sv
module msi_cap_gen #(
  parameter int NVEC = 32,
  localparam int IW = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strap_addr64,
  input  logic            strap_pvmask,
  input  logic [2:0]      strap_mmcap,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_addr,
  input  logic [2:0]      cfg_len,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic            cfg_err,
  output logic [4:0]      cap_bytes,
  input  logic [NVEC-1:0] irq_req,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [15:0]     msg_data
);

  logic            en_q;
  logic [2:0]      mme_q;
  logic [31:0]     alo_q, ahi_q;
  logic [15:0]     dat_q;
  logic [NVEC-1:0] mask_q, pend_q;

  wire [15:0] ctl      = {7'd0, strap_pvmask, strap_addr64, mme_q, strap_mmcap, en_q};
  wire [7:0]  off_data = strap_addr64 ? 8'h0C : 8'h08;
  wire [7:0]  off_mask = strap_addr64 ? 8'h10 : 8'h0C;
  wire [7:0]  off_pend = off_mask + 8'h04;
  wire [31:0] ahi_eff  = strap_addr64 ? ahi_q : 32'd0;

  assign cap_bytes = 5'd10 + (strap_addr64 ? 5'd4 : 5'd0) + (strap_pvmask ? 5'd10 : 5'd0);

  wire len2 = (cfg_len == 3'd2);
  wire len4 = (cfg_len == 3'd4);

  wire w_ctl = cfg_wr && ((len2 && cfg_addr == 8'h02) || (len4 && cfg_addr == 8'h00));
  wire w_alo = cfg_wr && len4 && cfg_addr == 8'h04;
  wire w_dat = cfg_wr && (len2 || len4) && cfg_addr == off_data;
  wire w_ahi = cfg_wr && len4 && strap_addr64 && cfg_addr == 8'h08;
  wire w_msk = cfg_wr && len4 && strap_pvmask && cfg_addr == off_mask;
  wire w_hit = w_ctl || w_alo || w_dat || w_ahi || w_msk;

  wire [15:0] ctl_val = len4 ? cfg_wdata[31:16] : cfg_wdata[15:0];

  wire [7:0] rd_off = {cfg_addr[7:2], 2'b00};

  always_comb begin
    cfg_rdata = 32'd0;
    if (rd_off == 8'h00)                          cfg_rdata = {ctl, 16'd0};
    else if (rd_off == 8'h04)                     cfg_rdata = {alo_q[31:2], 2'b00};
    else if (rd_off == off_data)                  cfg_rdata = {16'd0, dat_q};
    else if (strap_addr64 && rd_off == 8'h08)     cfg_rdata = ahi_q;
    else if (strap_pvmask && rd_off == off_mask)  cfg_rdata = 32'(mask_q);
    else if (strap_pvmask && rd_off == off_pend)  cfg_rdata = 32'(pend_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mme_q   <= 3'd0;
      alo_q   <= 32'd0;
      ahi_q   <= 32'd0;
      dat_q   <= 16'd0;
      mask_q  <= '0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= cfg_wr && !w_hit;
      if (w_ctl) begin
        en_q  <= ctl_val[0];
        mme_q <= ctl_val[6:4];
      end
      if (w_alo) alo_q  <= {cfg_wdata[31:2], 2'b00};
      if (w_dat) dat_q  <= cfg_wdata[15:0];
      if (w_ahi) ahi_q  <= cfg_wdata;
      if (w_msk) mask_q <= cfg_wdata[NVEC-1:0];
    end
  end

  logic [NVEC-1:0] vec_ok;
  always_comb begin
    for (int i = 0; i < NVEC; i++)
      vec_ok[i] = (mme_q <= 3'd5) && (32'(i) < (32'd1 << mme_q));
  end

  wire [NVEC-1:0] eff_mask = strap_pvmask ? mask_q : '0;
  wire [NVEC-1:0] elig     = pend_q & vec_ok & ~eff_mask & {NVEC{en_q}};

  logic          any;
  logic [IW-1:0] sel;
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any = 1'b1;
        sel = IW'(i);
      end
    end
  end

  wire             take   = !msg_valid || msg_ready;
  wire             launch = take && any;
  wire [NVEC-1:0]  clr    = launch ? (NVEC'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= 64'd0;
      msg_data  <= 16'd0;
    end else begin
      pend_q <= (pend_q & ~clr) | (irq_req & vec_ok);
      if (take) begin
        msg_valid <= any;
        if (any) begin
          msg_addr <= {ahi_eff, alo_q[31:2], 2'b00};
          msg_data <= dat_q | 16'(sel);
        end
      end
    end
  end

endmodule

// File: rtl/msi_cap_gen_chk.sv
module msi_cap_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [7:0]  cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        cfg_err,
  input logic [4:0]  cap_bytes,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [63:0] msg_addr,
  input logic [15:0] msg_data,
  input logic        en_q
);

  a_r13_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  a_r7_err_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_wr));

  a_r3_low_addr_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[7:2] == 6'd1) |-> (cfg_rdata[1:0] == 2'b00));

  a_r12_send_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(en_q));

  a_r8_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_bytes == 5'd10) || (cap_bytes == 5'd14) || (cap_bytes == 5'd20) || (cap_bytes == 5'd24));

endmodule

bind msi_cap_gen msi_cap_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .cap_bytes(cap_bytes),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data), .en_q(en_q)
);

// File: tb/msi_cap_gen_bench.sv
`timescale 1ns/1ps
module msi_cap_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_addr64 = 1'b1, strap_pvmask = 1'b1;
  logic [2:0]  strap_mmcap = 3'd5;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'd0;
  logic [2:0]  cfg_len = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic [4:0]  cap_bytes;
  logic [31:0] irq_req = 32'd0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [15:0] msg_data;

  int checks = 0, fails = 0;
  logic werr;
  logic got;
  logic [63:0] g_addr;
  logic [15:0] g_data;
  logic [31:0] rv;

  always #4 clk = ~clk;

  msi_cap_gen u_msi_cap_gen (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic a64, input logic pvm, input logic [2:0] mmc);
    @(negedge clk);
    strap_addr64 = a64; strap_pvmask = pvm; strap_mmcap = mmc; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] l, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_len = l; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    werr = cfg_err;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic req(input logic [31:0] v);
    @(negedge clk);
    irq_req = v;
    @(negedge clk);
    irq_req = 32'd0;
  endtask

  task automatic get_msg();
    got = 1'b0;
    for (int i = 0; i < 12 && !got; i++) begin
      @(negedge clk);
      if (msg_valid) begin
        got = 1'b1; g_addr = msg_addr; g_data = msg_data;
      end
    end
  endtask

  task automatic no_msg(input string req_tag);
    logic seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(req_tag, seen, 1'b0);
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b1, 3'd5);
    rd(8'h00, rv); chk("R1 reset control", rv, 32'h018A_0000);
    chk("R8 size 64+pvm", cap_bytes, 5'd24);
    chk("R1 reset no message", msg_valid, 1'b0);
  endtask

  task automatic t_ctl();
    wr(8'h00, 3'd4, 32'hFFFF_0000); rd(8'h00, rv); chk("R2 dword control write", rv, 32'h01FB_0000);
    wr(8'h02, 3'd2, 32'h0000_0000); rd(8'h02, rv); chk("R2 half control write", rv, 32'h018A_0000);
    wr(8'h02, 3'd2, 32'h0000_FF31); rd(8'h00, rv); chk("R2 only en and mme", rv, 32'h01BB_0000);
  endtask

  task automatic t_regs64();
    wr(8'h04, 3'd4, 32'h1234_5677); rd(8'h04, rv); chk("R3 low addr bits zero", rv, 32'h1234_5674);
    wr(8'h08, 3'd4, 32'hCAFE_0001); rd(8'h08, rv); chk("R4 upper addr at 0x8", rv, 32'hCAFE_0001);
    wr(8'h0C, 3'd2, 32'h0000_0005); rd(8'h0C, rv); chk("R4 data at 0xC", rv, 32'h0000_0005);
    wr(8'h0C, 3'd4, 32'hABCD_0006); rd(8'h0C, rv); chk("R6 dword data keeps low half", rv, 32'h0000_0006);
    wr(8'h10, 3'd4, 32'h0000_0000); rd(8'h10, rv); chk("R4 mask at 0x10", rv, 32'h0);
  endtask

  task automatic t_err();
    wr(8'h14, 3'd4, 32'hFFFF_FFFF); chk("R7 pending write flagged", werr, 1'b1);
    @(negedge clk); chk("R7 flag lasts one cycle", cfg_err, 1'b0);
    wr(8'h04, 3'd1, 32'h0000_00FF); chk("R7 bad length flagged", werr, 1'b1);
    rd(8'h04, rv); chk("R7 bad length ignored", rv, 32'h1234_5674);
    wr(8'h04, 3'd4, 32'h1234_5674); chk("R7 good write no flag", werr, 1'b0);
    rd(8'h18, rv); chk("R7 absent read zero", rv, 32'h0);
  endtask

  task automatic t_msg();
    req(32'h8); get_msg();
    chk("R10 message seen", got, 1'b1);
    chk("R10 address joined", g_addr, 64'hCAFE_0001_1234_5674);
    chk("R10 data ORed with index", g_data, 16'h0007);
  endtask

  task automatic t_prio();
    wr(8'h0C, 3'd2, 32'h0000_0010);
    msg_ready = 1'b0;
    req(32'h0000_002A); get_msg();
    chk("R13 lowest first", g_data, 16'h0011);
    repeat (3) @(negedge clk);
    chk("R13 held while stalled", {msg_valid, msg_data}, {1'b1, 16'h0011});
    msg_ready = 1'b1;
    get_msg(); chk("R13 second in order", g_data, 16'h0013);
    get_msg(); chk("R13 third in order", g_data, 16'h0015);
    no_msg("R13 one per vector");
  endtask

  task automatic t_mask();
    wr(8'h10, 3'd4, 32'h0000_0004);
    req(32'h4); no_msg("R11 masked vector silent");
    rd(8'h14, rv); chk("R11 masked request pending", rv, 32'h4);
    wr(8'h10, 3'd4, 32'h0); get_msg();
    chk("R11 sent after unmask", {got, g_data}, {1'b1, 16'h0012});
    rd(8'h14, rv); chk("R11 pending cleared", rv, 32'h0);
  endtask

  task automatic t_dis();
    wr(8'h02, 3'd2, 32'h0000_0030);
    req(32'h1); no_msg("R12 disabled silent");
    wr(8'h02, 3'd2, 32'h0000_0031); get_msg();
    chk("R12 sent after enable", {got, g_data}, {1'b1, 16'h0010});
  endtask

  task automatic t_vcount();
    wr(8'h02, 3'd2, 32'h0000_0001);
    req(32'h2); no_msg("R9 vector above count silent");
    rd(8'h14, rv); chk("R9 vector above count not pending", rv, 32'h0);
    req(32'h1); get_msg(); chk("R9 vector 0 usable", {got, g_data}, {1'b1, 16'h0010});
    wr(8'h02, 3'd2, 32'h0000_0061);
    req(32'h1); no_msg("R9 mme 6 gives no vectors");
    rd(8'h14, rv); chk("R9 mme 6 not pending", rv, 32'h0);
  endtask

  task automatic t_layout32();
    do_reset(1'b0, 1'b0, 3'd0);
    chk("R8 size plain", cap_bytes, 5'd10);
    wr(8'h08, 3'd4, 32'h0000_1234); rd(8'h08, rv); chk("R5 data at 0x8", rv, 32'h0000_1234);
    wr(8'h0C, 3'd4, 32'h0000_0001); chk("R5 no mask without strap", werr, 1'b1);
    rd(8'h0C, rv); chk("R5 absent mask reads zero", rv, 32'h0);
    do_reset(1'b0, 1'b1, 3'd0);
    chk("R8 size 32+pvm", cap_bytes, 5'd20);
    wr(8'h0C, 3'd4, 32'h0000_0001); rd(8'h0C, rv); chk("R5 mask at 0xC", rv, 32'h1);
    wr(8'h08, 3'd2, 32'h0000_1234);
    wr(8'h04, 3'd4, 32'h0000_0100);
    wr(8'h02, 3'd2, 32'h0000_0001);
    req(32'h1); no_msg("R11 masked in 32-bit layout");
    rd(8'h10, rv); chk("R5 pending at 0x10", rv, 32'h1);
    wr(8'h0C, 3'd4, 32'h0); get_msg();
    chk("R5 upper address zero", g_addr, 64'h0000_0000_0000_0100);
    chk("R10 data in 32-bit layout", g_data, 16'h1234);
  endtask

  initial begin
    t_reset(); t_ctl(); t_regs64(); t_err(); t_msg();
    t_prio(); t_mask(); t_dis(); t_vcount(); t_layout32();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule